// File: doc/BRIEF.md
# Dual-Protocol Multiplexed Address/Data Bus Slave

This block is the slave end of an 8-bit multiplexed address/data bus that reaches into a 128-byte space of registers and RAM. A single set of bus pins carries one of two protocols, chosen by a mode input.

In strobe/direction mode the host uses an address strobe, an active-high data strobe and a read/write level. In separate-enable mode it uses an address-latch pulse, an active-low read enable and an active-low write enable.

Every bus input is synchronized into the system clock before use. The block latches the 7-bit address and issues single-cycle write pulses toward a byte-wide register file. Each write pulse carries a mask of the bits that may be written. During a read the block drives the register file's data back onto the bus through an output enable. After each read it emits a read-done pulse, so that clear-on-read registers change only once the data has been delivered.

There is no back-pressure anywhere in this block. The host bus cannot be stalled, so the register file must accept every write pulse in the cycle it appears and must present read data combinationally for the address on `reg_addr`. None of the outputs uses a valid/ready handshake.

Top module: `mux_bus_slave`

## Requirements
- R1: `bus_mode`=1 selects strobe/direction protocol: `ds_rd` is an active-high data strobe and `rw_wr` high during it means read, low means write. `bus_mode`=0 selects separate-enable protocol: `ds_rd` is an active-low read enable and `rw_wr` an active-low write enable.
- R2: On a falling edge of `as_ale`, bits 6:0 of `ad_in` are latched as the address and presented on `reg_addr`.
- R3: A rising edge of `as_ale` clears the latched address to 0 and invalidates it, whatever `cs_n` is. A data-phase strobe with no fresh latch performs no access.
- R4: A write ends at the trailing edge of the write strobe. That edge produces exactly one single-cycle `reg_wr_en` pulse, with `reg_wr_data` equal to the bus value held during the strobe.
- R5: While a read strobe is active with `cs_n` low and a valid address, `ad_oe` is 1 and `ad_out` equals `reg_rd_data`. `ad_oe` returns to 0 when the strobe ends.
- R6: With `cs_n` high during the data phase, there is no write pulse, no bus drive and no read-done pulse.
- R7: Addresses 0x0C and 0x0D are read-only, and a write to them produces no `reg_wr_en`.
- R8: A write to 0x00 or 0x0A carries `reg_wr_mask`=0x7F, which protects bit 7. Writes to every other writable address carry 0xFF.
- R9: After each read, `reg_rd_done` pulses for one cycle once the read strobe has ended. It never coincides with `reg_wr_en`, and `reg_addr` still holds the read address during the pulse.
- R10: While `rst_n` is low, the block performs no access: `ad_oe`, `reg_wr_en` and `reg_rd_done` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; blocks all accesses while low |
| bus_mode | input | 1 | 1 = strobe/direction protocol, 0 = separate-enable protocol |
| as_ale | input | 1 | Address strobe / address-latch pulse, active high |
| ds_rd | input | 1 | Data strobe (mode 1) or active-low read enable (mode 0) |
| rw_wr | input | 1 | Read/write level (mode 1) or active-low write enable (mode 0) |
| cs_n | input | 1 | Active-low chip select |
| ad_in | input | 8 | Multiplexed address/data from the host |
| ad_out | output | 8 | Read data toward the host |
| ad_oe | output | 1 | Drive enable for `ad_out` |
| reg_addr | output | 7 | Latched address toward the register file |
| reg_wr_en | output | 1 | Single-cycle write pulse |
| reg_wr_data | output | 8 | Write data |
| reg_wr_mask | output | 8 | Writable-bit mask for this write |
| reg_rd_data | input | 8 | Register file data at `reg_addr` |
| reg_rd_done | output | 1 | Single-cycle pulse after a completed read |

## Verification
The bench runs both protocols through writes and reads in a vector table, including writes to the read-only bytes and to the two bytes whose bit 7 is protected. A design that ignored the protection would let 0xFF through or would pulse a write to 0x0C/0x0D.

Directed cases cover the following failure modes:
- A cycle with chip select high; a design that skipped the qualification would write or drive the bus anyway.
- A data strobe after the address strobe rose again without falling; a design that kept the stale address would write to it.
- Read/write direction decoding in each mode; a confused design would write on a read.
- A full write cycle during reset; a design that did not gate on reset would emit a pulse.

// File: rtl/mbs_pkg.sv
`timescale 1ns/1ps
package mbs_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] SECS_ADDR  = 7'h00;
  localparam logic [ADDR_W-1:0] CTLA_ADDR  = 7'h0A;
  localparam logic [ADDR_W-1:0] FLAGS_ADDR = 7'h0C;
  localparam logic [ADDR_W-1:0] STAT_ADDR  = 7'h0D;

  function automatic logic write_allowed(input logic [ADDR_W-1:0] a);
    return (a != FLAGS_ADDR) && (a != STAT_ADDR);
  endfunction

  function automatic logic [DATA_W-1:0] write_mask(input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] m;
    m = '1;
    if (a == SECS_ADDR || a == CTLA_ADDR) m[DATA_W-1] = 1'b0;
    return m;
  endfunction
endpackage

// File: rtl/mbs_sync.sv
`timescale 1ns/1ps
module mbs_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[i] <= RST_VAL;
        else if (i == 0) st[i] <= d;
        else st[i] <= st[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/mbs_addr_latch.sv
`timescale 1ns/1ps
module mbs_addr_latch
  import mbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              as_s,
  input  logic [ADDR_W-1:0] ad_s,
  output logic [ADDR_W-1:0] addr,
  output logic              addr_vld
);
  logic as_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      as_p     <= 1'b0;
      addr     <= '0;
      addr_vld <= 1'b0;
    end else begin
      as_p <= as_s;
      if (as_p && !as_s) begin
        addr     <= ad_s;
        addr_vld <= 1'b1;
      end else if (!as_p && as_s) begin
        addr     <= '0;
        addr_vld <= 1'b0;
      end
    end
  end

  AST_ADDR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (as_s && !as_p) |=> (addr == '0 && !addr_vld)) else $error("addr not cleared"); // R3
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (as_s == as_p) |=> $stable(addr)) else $error("addr moved without strobe edge"); // R2
endmodule

// File: rtl/mbs_access_ctl.sv
`timescale 1ns/1ps
module mbs_access_ctl
  import mbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode,
  input  logic              ds_s,
  input  logic              rw_s,
  input  logic              cs_n_s,
  input  logic [DATA_W-1:0] ad_s,
  input  logic [ADDR_W-1:0] addr,
  input  logic              addr_vld,
  output logic              rd_live,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] wr_mask,
  output logic              rd_done
);
  logic rd_strb, wr_strb, sel, wr_live;
  logic rd_live_q, wr_live_q;
  logic [DATA_W-1:0] wdat_q;

  // Protocol decode: strobe polarity and meaning depend on mode
  always_comb begin
    if (mode) begin
      rd_strb = ds_s & rw_s;
      wr_strb = ds_s & ~rw_s;
    end else begin
      rd_strb = ~ds_s;
      wr_strb = ~rw_s;
    end
    sel     = ~cs_n_s & addr_vld & rst_n;
    rd_live = rd_strb & sel;
    wr_live = wr_strb & sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_live_q <= 1'b0;
      wr_live_q <= 1'b0;
      wdat_q    <= '0;
      wr_en     <= 1'b0;
      wr_data   <= '0;
      wr_mask   <= '0;
      rd_done   <= 1'b0;
    end else begin
      rd_live_q <= rd_live;
      wr_live_q <= wr_live;
      if (wr_live) wdat_q <= ad_s;
      wr_en   <= wr_live_q & ~wr_strb & write_allowed(addr);
      wr_data <= wdat_q;
      wr_mask <= write_mask(addr);
      rd_done <= rd_live_q & ~rd_strb;
    end
  end

  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en) else $error("write pulse too long"); // R4
  AST_RD_WR_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_done)) else $error("read done with write"); // R9
  AST_DONE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> $past(rd_live, 2)) else $error("read done without read"); // R9
endmodule

// File: rtl/mux_bus_slave.sv
`timescale 1ns/1ps
module mux_bus_slave
  import mbs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_mode,
  input  logic              as_ale,
  input  logic              ds_rd,
  input  logic              rw_wr,
  input  logic              cs_n,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_wr_en,
  output logic [DATA_W-1:0] reg_wr_data,
  output logic [DATA_W-1:0] reg_wr_mask,
  input  logic [DATA_W-1:0] reg_rd_data,
  output logic              reg_rd_done
);
  localparam int CTL_W = 5;

  logic [CTL_W-1:0]  ctl_s;
  logic [DATA_W-1:0] ad_s;
  logic              addr_vld, rd_live;

  // control order: mode, as, ds, rw, cs_n (cs_n idles high)
  mbs_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(5'b00011)) i_ctl_sync (
    .clk(clk), .rst_n(rst_n),
    .d({bus_mode, as_ale, ds_rd, rw_wr, cs_n}), .q(ctl_s));

  mbs_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) i_ad_sync (
    .clk(clk), .rst_n(rst_n), .d(ad_in), .q(ad_s));

  mbs_addr_latch i_alat (
    .clk(clk), .rst_n(rst_n), .as_s(ctl_s[3]), .ad_s(ad_s[ADDR_W-1:0]),
    .addr(reg_addr), .addr_vld(addr_vld));

  mbs_access_ctl i_acc (
    .clk(clk), .rst_n(rst_n), .mode(ctl_s[4]), .ds_s(ctl_s[2]), .rw_s(ctl_s[1]),
    .cs_n_s(ctl_s[0]), .ad_s(ad_s), .addr(reg_addr), .addr_vld(addr_vld),
    .rd_live(rd_live), .wr_en(reg_wr_en), .wr_data(reg_wr_data),
    .wr_mask(reg_wr_mask), .rd_done(reg_rd_done));

  assign ad_oe  = rd_live;
  assign ad_out = rd_live ? reg_rd_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) AST_NO_DRIVE_IN_RESET: assert (!ad_oe && !reg_wr_en) else $error("access in reset"); // R10
  end
  AST_RO_NOT_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> (reg_addr != FLAGS_ADDR && reg_addr != STAT_ADDR)) else $error("ro write"); // R7
  AST_BIT7_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && (reg_addr == SECS_ADDR || reg_addr == CTLA_ADDR)) |-> !reg_wr_mask[DATA_W-1])
    else $error("bit7 not protected"); // R8
  AST_ADDR_STABLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (ad_oe && $past(ad_oe)) |-> $stable(reg_addr)) else $error("addr moved in read"); // R5
endmodule

// File: tb/test_mux_bus_slave.sv
`timescale 1ns/1ps
module test_mux_bus_slave;
  logic clk = 0, rst_n = 0, bus_mode = 1, as_ale = 0, ds_rd = 0, rw_wr = 1, cs_n = 1;
  logic [7:0] ad_in = 0, ad_out, reg_wr_data, reg_wr_mask, reg_rd_data;
  logic [6:0] reg_addr;
  logic ad_oe, reg_wr_en, reg_rd_done;
  logic [7:0] mem [128];
  int wr_cnt = 0, rd_cnt = 0, checks = 0, fails = 0;
  logic [6:0] last_rd_addr = 0;

  always #5 clk = ~clk;

  mux_bus_slave i_mux_bus_slave (.*);

  assign reg_rd_data = mem[reg_addr];

  always @(posedge clk) begin
    if (reg_wr_en) begin
      mem[reg_addr] <= (mem[reg_addr] & ~reg_wr_mask) | (reg_wr_data & reg_wr_mask);
      wr_cnt <= wr_cnt + 1;
    end
    if (reg_rd_done) begin
      rd_cnt <= rd_cnt + 1;
      last_rd_addr <= reg_addr;
    end
  end

  // fields: mode[25] wr[24] addr[23:17] data[16:9] exp[8:1] pulse[0]
  localparam logic [25:0] VEC [12] = '{
    {1'b1, 1'b1, 7'h10, 8'hA5, 8'hA5, 1'b1},
    {1'b0, 1'b1, 7'h20, 8'h3C, 8'h3C, 1'b1},
    {1'b1, 1'b0, 7'h20, 8'h00, 8'h3C, 1'b1},
    {1'b0, 1'b0, 7'h10, 8'h00, 8'hA5, 1'b1},
    {1'b1, 1'b1, 7'h00, 8'hFF, 8'h7F, 1'b1},
    {1'b0, 1'b1, 7'h0A, 8'h9B, 8'h1B, 1'b1},
    {1'b0, 1'b1, 7'h0C, 8'h55, 8'h00, 1'b0},
    {1'b1, 1'b1, 7'h0D, 8'h66, 8'h00, 1'b0},
    {1'b1, 1'b1, 7'h0B, 8'h80, 8'h80, 1'b1},
    {1'b0, 1'b0, 7'h0B, 8'h00, 8'h80, 1'b1},
    {1'b1, 1'b1, 7'h7F, 8'h11, 8'h11, 1'b1},
    {1'b0, 1'b0, 7'h7F, 8'h00, 8'h11, 1'b1}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_cycle(input bit mode, input bit wr, input logic [6:0] a,
                           input logic [7:0] d, input bit sel, input bit do_latch,
                           output logic [7:0] rd_val, output logic oe_seen);
    as_ale = 1; step(4);
    bus_mode = mode; ds_rd = mode ? 1'b0 : 1'b1; rw_wr = 1; cs_n = 1;
    ad_in = {1'b0, a}; step(4);
    if (do_latch) begin as_ale = 0; step(4); end
    cs_n = ~sel;
    if (wr) begin
      ad_in = d; rw_wr = 0;
      if (mode) ds_rd = 1;
      step(4);
      if (mode) begin ds_rd = 0; step(4); rw_wr = 1; end
      else begin rw_wr = 1; step(4); end
      rd_val = 0; oe_seen = ad_oe;
    end else begin
      ad_in = 8'hEE;
      if (mode) begin rw_wr = 1; ds_rd = 1; end else ds_rd = 0;
      step(4);
      rd_val = ad_out; oe_seen = ad_oe;
      ds_rd = mode ? 1'b0 : 1'b1;
      step(4);
    end
    cs_n = 1; step(2);
  endtask

  initial begin
    logic [7:0] rv;
    logic oe;
    int w0, r0;
    for (int i = 0; i < 128; i++) mem[i] = 8'h00;

    // R10: reset state and a full write attempted during reset
    step(3);
    chk("R10 oe in reset", ad_oe, 0);
    chk("R10 done in reset", reg_rd_done, 0);
    bus_cycle(1, 1, 7'h30, 8'h77, 1, 1, rv, oe);
    chk("R10 no write in reset", wr_cnt, 0);
    chk("R10 mem untouched", mem[7'h30], 8'h00);
    as_ale = 1; step(2);
    rst_n = 1; step(4);

    // vector table
    for (int k = 0; k < 12; k++) begin
      logic [25:0] v;
      v = VEC[k];
      w0 = wr_cnt; r0 = rd_cnt;
      bus_cycle(v[25], v[24], v[23:17], v[16:9], 1, 1, rv, oe);
      if (v[24]) begin
        chk("R4/R7 write pulse count", wr_cnt - w0, {31'b0, v[0]});
        chk("R4/R8 stored value", mem[v[23:17]], v[8:1]);
        chk("R6 no drive during write", oe, 0);
      end else begin
        chk("R5 read data", rv, v[8:1]);
        chk("R1 read does not write", wr_cnt - w0, 0);
        chk("R9 one read done", rd_cnt - r0, 1);
        chk("R9 done address", last_rd_addr, v[23:17]);
        chk("R5 released after strobe", ad_oe, 0);
      end
    end

    // R6: chip select high
    w0 = wr_cnt; r0 = rd_cnt;
    bus_cycle(1, 1, 7'h40, 8'h99, 0, 1, rv, oe);
    chk("R6 no write without cs", wr_cnt - w0, 0);
    bus_cycle(0, 0, 7'h10, 8'h00, 0, 1, rv, oe);
    chk("R6 no drive without cs", oe, 0);
    chk("R6 no done without cs", rd_cnt - r0, 0);

    // R2/R3: latch then clear on rising strobe
    bus_mode = 0; ds_rd = 1; rw_wr = 1;
    as_ale = 1; ad_in = 8'h55; step(4);
    as_ale = 0; step(4);
    chk("R2 latched address", reg_addr, 7'h55);
    as_ale = 1; step(4);
    chk("R3 cleared address", reg_addr, 7'h00);
    w0 = wr_cnt;
    bus_cycle(0, 1, 7'h22, 8'h44, 1, 0, rv, oe);
    chk("R3 no write without fresh latch", wr_cnt - w0, 0);
    chk("R3 mem 0 untouched", mem[0], 8'h7F);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule